// File: doc/BRIEF.md
# Asynchronous Serial Transceiver with Selectable Bit Clock

The block sends and receives asynchronous serial characters. Its timing comes from a tick at sixteen times the bit rate. That tick is either an internal tick pulse from a baud-rate generator outside the block, or the rising edges of an external serial clock input, which is synchronised first. When the internal tick is in use and the clock output is enabled, the block drives a clock at the bit rate on its serial clock output. The rising edge of that clock falls at the centre of every bit of the frame in progress. The clock output rests high between frames.

A character frame has these parts in order: a low start bit, then 7 or 8 data bits sent least significant bit first, then an optional even or odd parity bit, then one or two high stop bits. The transmitter takes a byte through a single holding register and raises a flag while that register is free. The receiver watches the line for a falling edge and confirms the start bit half a bit later. It then samples every further bit at its middle. A finished character lands in a data register, and the block reports full, parity, framing and overrun conditions for it.

The frame format, the tick source and the clock output enable are taken in only while both the transmitter and the receiver are disabled. Turning off the transmitter abandons any frame in progress and frees the holding register. Turning off the receiver stops reception but keeps the received data and every receive flag as they were.

Top module: `sercom_async`

## Requirements
- R1: The transmit line idles high. A frame is a low start bit, then the data bits least significant first, then the parity bit when enabled, then one or two high stop bits, and every bit lasts 16 ticks.
- R2: The receiver starts a frame on a falling edge of the line and confirms the start bit if the line is still low at the 8th tick. It then samples each later bit every 16 ticks. A low pulse that ends before the 8th tick produces no character.
- R3: With parity enabled, the parity bit is chosen so that the data bits plus the parity bit hold an even count of ones when odd selection is 0, or an odd count when it is 1. A received character whose parity bit disagrees sets the parity error flag.
- R4: A received character with any stop bit sampled low sets the framing error flag.
- R5: A character that completes while the receive-full flag is still set sets the overrun flag and leaves the receive data register and the full flag unchanged.
- R6: A write to the transmit holding register while the transmitter is enabled clears the transmit-empty flag. The flag sets again on the tick where the byte moves into the shift register.
- R7: Clearing the transmit enable sets the transmit-empty flag, returns the line high and abandons the frame.
- R8: While the receive enable is 0, the receive data register and the full, parity, framing and overrun flags keep their values, even if a frame arrives on the line.
- R9: Tick source, clock output enable and frame format are captured only while both enables are 0. Changes made while either enable is 1 have no effect.
- R10: With the external source selected, each rising edge of the external clock input is one tick, 16 per bit, and the internal tick is ignored.
- R11: With the internal source and the clock output enabled, the serial clock output falls at the start of each bit and rises at its centre, and it is high while no frame is in progress. With the external source selected or the output disabled, it stays high.
- R12: In 7-bit format, bit 7 of the receive data register reads 0. A pulse on the flag clear input clears the full, parity, framing and overrun flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| int_tick | input | 1 | Internal 16x tick pulse, one clock wide |
| ext_sclk_in | input | 1 | External serial clock at 16x the bit rate |
| cfg_ext_clk | input | 1 | 1 selects the external clock as tick source |
| cfg_clk_out | input | 1 | 1 enables the bit-rate clock output (internal source only) |
| cfg_data7 | input | 1 | 1 selects 7 data bits, 0 selects 8 |
| cfg_par_en | input | 1 | 1 adds a parity bit |
| cfg_par_odd | input | 1 | 1 selects odd parity, 0 even |
| cfg_stop2 | input | 1 | 1 selects two stop bits |
| tx_en | input | 1 | Transmit enable |
| rx_en | input | 1 | Receive enable |
| tdr_wr | input | 1 | Write strobe for the transmit holding register |
| tdr_data | input | 8 | Byte to transmit |
| tdr_empty | output | 1 | Transmit holding register is free |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| flag_clr | input | 1 | Clears the four receive flags |
| rdr | output | 8 | Receive data register |
| rdr_full | output | 1 | Receive data register holds an unread character |
| par_err | output | 1 | Parity error flag |
| frm_err | output | 1 | Framing error flag |
| ovr_err | output | 1 | Overrun error flag |
| sclk_out | output | 1 | Bit-rate clock output |

## Verification
The bench sweeps all sixteen frame formats through a loopback. It checks every transmitted bit at its centre and every received byte. A transmitter with a wrong bit order, a wrong parity sense or a miscounted stop bit fails the sweep, and so does a receiver that samples off the bit centre. A monitor measures each rising edge of the clock output against the last transmit line edge, which catches a clock skewed by half a bit. Injected faults cover bad parity, a low stop bit, a second character into a full register and a short low glitch. A design that loses the rejection or overwrites data on overrun fails these. Further tests check that configuration is not taken in while enabled, that receive state survives disable, that dropping transmit enable frees the holding register, and that no internal tick advances the frame in external mode. These catch a missing lock, a reset-on-disable, a stale empty flag and a wrong tick multiplexer.

// File: rtl/sercom_pkg.sv
package sercom_pkg;

   typedef struct packed {
      logic ext_clk;
      logic clk_out;
      logic data7;
      logic par_en;
      logic par_odd;
      logic stop2;
   } fmt_cfg_t;

   typedef enum logic [1:0] {
      RX_IDLE  = 2'd0,
      RX_START = 2'd1,
      RX_BITS  = 2'd2
   } rx_state_t;

endpackage

// File: rtl/sercom_tick_sel.sv
module sercom_tick_sel #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic use_ext,
   input  logic int_tick,
   input  logic ext_clk_in,
   output logic tick
);

   localparam int MSB = SYNC_STAGES - 1;

   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic [SYNC_STAGES-1:0] sync_q;
   logic                   ext_prev;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q   <= '0;
         ext_prev <= 1'b0;
      end else begin
         sync_q   <= {sync_q[SYNC_STAGES-2:0], ext_clk_in};
         ext_prev <= sync_q[MSB];
      end
   end

   // one tick per rising edge of the synchronised external clock
   assign tick = use_ext ? (sync_q[MSB] & ~ext_prev) : int_tick;

endmodule

// File: rtl/sercom_tx.sv
module sercom_tx #(
   parameter int DATA_W = 8,
   parameter int OSR    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              te,
   input  logic              data7,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop2,
   input  logic              tdr_wr,
   input  logic [DATA_W-1:0] tdr_data,
   output logic              tdr_empty,
   output logic              txd,
   output logic              busy,
   output logic              clk_lo
);

   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);
   localparam int PH_W    = $clog2(OSR);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);

   logic [DATA_W-1:0]  tdr_q;
   logic [FRAME_W-1:0] shreg;
   logic [FRAME_W-1:0] frame_v;
   logic [CNT_W-1:0]   left;
   logic [CNT_W-1:0]   nbits;
   logic [PH_W-1:0]    ph;
   logic [DATA_W-1:0]  dval;
   logic               last_bit;
   logic               start;
   int                 nd;

   always_comb begin
      nd   = data7 ? DATA_W - 1 : DATA_W;
      dval = tdr_q;
      if (data7) dval[DATA_W-1] = 1'b0;
      frame_v    = '1;
      frame_v[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (i < nd) frame_v[1+i] = dval[i];
      end
      if (par_en) frame_v[1+nd] = (^dval) ^ par_odd;
      nbits = CNT_W'(1 + nd + (par_en ? 1 : 0) + (stop2 ? 2 : 1));
   end

   assign last_bit = busy && tick && (ph == PH_LAST) && (left == '0);
   assign start    = te && !tdr_empty && tick && (!busy || last_bit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tdr_q     <= '0;
         tdr_empty <= 1'b1;
         shreg     <= '1;
         left      <= '0;
         ph        <= '0;
         busy      <= 1'b0;
         txd       <= 1'b1;
      end else if (!te) begin
         tdr_empty <= 1'b1;
         busy      <= 1'b0;
         txd       <= 1'b1;
         ph        <= '0;
      end else begin
         if (start) begin
            tdr_empty <= 1'b1;
            busy      <= 1'b1;
            txd       <= frame_v[0];
            shreg     <= frame_v >> 1;
            left      <= nbits - 1'b1;
            ph        <= '0;
         end else if (busy && tick) begin
            ph <= ph + 1'b1;
            if (ph == PH_LAST) begin
               if (left == '0) begin
                  busy <= 1'b0;
                  txd  <= 1'b1;
               end else begin
                  txd   <= shreg[0];
                  shreg <= shreg >> 1;
                  left  <= left - 1'b1;
               end
            end
         end
         if (tdr_wr) begin
            tdr_q     <= tdr_data;
            tdr_empty <= 1'b0;
         end
      end
   end

   // low over the first half of each bit, so the rise lands mid-bit
   assign clk_lo = busy & ~ph[PH_W-1];

   a_r7_te_off_empty: assert property (@(posedge clk) disable iff (!rst_n)
      !te |=> (tdr_empty && txd));

   a_r6_wr_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (te && tdr_wr) |=> !tdr_empty);

   a_r1_idle_line: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> txd);

endmodule

// File: rtl/sercom_rx.sv
module sercom_rx
   import sercom_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick,
   input  logic              re,
   input  logic              data7,
   input  logic              par_en,
   input  logic              par_odd,
   input  logic              stop2,
   input  logic              rxd,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rdr,
   output logic              rdr_full,
   output logic              par_err,
   output logic              frm_err,
   output logic              ovr_err,
   output logic              busy,
   output logic              clk_lo
);

   localparam int RXB_W = DATA_W + 3;
   localparam int CNT_W = $clog2(RXB_W + 1);
   localparam int PH_W  = $clog2(OSR);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(OSR - 1);
   localparam logic [PH_W-1:0] PH_CONF = PH_W'(OSR / 2 - 1);

   rx_state_t          state;
   logic [SYNC_STAGES-1:0] sync_q;
   logic               line;
   logic               line_prev;
   logic [PH_W-1:0]    ph;
   logic [CNT_W-1:0]   pos;
   logic [CNT_W-1:0]   total;
   logic [RXB_W-1:0]   bits_q;
   logic [RXB_W-1:0]   fr_next;
   logic [DATA_W-1:0]  dval;
   logic               bad_par;
   logic               bad_stop;
   logic               sample;
   logic               done;
   logic               full_eff;
   int                 nd;
   int                 sidx;

   assign line = sync_q[SYNC_STAGES-1];

   always_comb begin
      nd      = data7 ? DATA_W - 1 : DATA_W;
      sidx    = nd + (par_en ? 1 : 0);
      total   = CNT_W'(sidx + (stop2 ? 2 : 1));
      fr_next = bits_q;
      fr_next[pos] = line;
      dval = fr_next[DATA_W-1:0];
      if (data7) dval[DATA_W-1] = 1'b0;
      bad_par  = par_en && (fr_next[nd] != ((^dval) ^ par_odd));
      bad_stop = !fr_next[sidx] || (stop2 && !fr_next[sidx+1]);
   end

   assign sample   = (state == RX_BITS) && tick && (ph == PH_LAST);
   assign done     = re && sample && (pos == total - 1'b1);
   assign full_eff = rdr_full && !flag_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q    <= '1;
         line_prev <= 1'b1;
         state     <= RX_IDLE;
         ph        <= '0;
         pos       <= '0;
         bits_q    <= '0;
      end else begin
         sync_q    <= {sync_q[SYNC_STAGES-2:0], rxd};
         line_prev <= line;
         if (!re) begin
            state <= RX_IDLE;
         end else begin
            case (state)
               RX_IDLE: if (line_prev && !line) begin
                  state <= RX_START;
                  ph    <= '0;
               end
               RX_START: if (tick) begin
                  if (ph == PH_CONF) begin
                     state <= line ? RX_IDLE : RX_BITS;
                     ph    <= '0;
                     pos   <= '0;
                  end else begin
                     ph <= ph + 1'b1;
                  end
               end
               RX_BITS: if (tick) begin
                  ph <= ph + 1'b1;
                  if (ph == PH_LAST) begin
                     bits_q <= fr_next;
                     pos    <= pos + 1'b1;
                     if (pos == total - 1'b1) state <= RX_IDLE;
                  end
               end
               default: state <= RX_IDLE;
            endcase
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdr      <= '0;
         rdr_full <= 1'b0;
         par_err  <= 1'b0;
         frm_err  <= 1'b0;
         ovr_err  <= 1'b0;
      end else begin
         if (flag_clr) begin
            rdr_full <= 1'b0;
            par_err  <= 1'b0;
            frm_err  <= 1'b0;
            ovr_err  <= 1'b0;
         end
         if (done) begin
            if (full_eff) begin
               ovr_err <= 1'b1;
            end else begin
               rdr      <= dval;
               rdr_full <= 1'b1;
               par_err  <= bad_par;
               frm_err  <= bad_stop;
            end
         end
      end
   end

   assign busy   = (state != RX_IDLE);
   // rise at the sample point of each bit
   assign clk_lo = (state == RX_START) | ((state == RX_BITS) & ph[PH_W-1]);

   a_r8_re_off_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!re && !flag_clr) |=> ($stable(rdr) && $stable(rdr_full) && $stable(par_err)
                              && $stable(frm_err) && $stable(ovr_err)));

   a_r5_overrun_keeps: assert property (@(posedge clk) disable iff (!rst_n)
      (done && rdr_full && !flag_clr) |=> ($stable(rdr) && ovr_err && rdr_full));

   a_r12_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_clr && !done) |=> !(rdr_full || par_err || frm_err || ovr_err));

endmodule

// File: rtl/sercom_async.sv
module sercom_async
   import sercom_pkg::*;
#(
   parameter int DATA_W      = 8,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              int_tick,
   input  logic              ext_sclk_in,
   input  logic              cfg_ext_clk,
   input  logic              cfg_clk_out,
   input  logic              cfg_data7,
   input  logic              cfg_par_en,
   input  logic              cfg_par_odd,
   input  logic              cfg_stop2,
   input  logic              tx_en,
   input  logic              rx_en,
   input  logic              tdr_wr,
   input  logic [DATA_W-1:0] tdr_data,
   output logic              tdr_empty,
   output logic              txd,
   input  logic              rxd,
   input  logic              flag_clr,
   output logic [DATA_W-1:0] rdr,
   output logic              rdr_full,
   output logic              par_err,
   output logic              frm_err,
   output logic              ovr_err,
   output logic              sclk_out
);

   if (OSR < 4 || (OSR & (OSR - 1)) != 0) begin : g_bad_osr
      $error("OSR must be a power of two, at least 4");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("DATA_W must be at least 2");
   end

   fmt_cfg_t cfg_q;
   logic     tick;
   logic     tx_busy;
   logic     tx_lo;
   logic     rx_busy;
   logic     rx_lo;
   logic     clk_lo;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (!tx_en && !rx_en) begin
         cfg_q <= '{ext_clk: cfg_ext_clk, clk_out: cfg_clk_out, data7: cfg_data7,
                    par_en: cfg_par_en, par_odd: cfg_par_odd, stop2: cfg_stop2};
      end
   end

   sercom_tick_sel #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
      .clk        (clk),
      .rst_n      (rst_n),
      .use_ext    (cfg_q.ext_clk),
      .int_tick   (int_tick),
      .ext_clk_in (ext_sclk_in),
      .tick       (tick)
   );

   sercom_tx #(.DATA_W(DATA_W), .OSR(OSR)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick      (tick),
      .te        (tx_en),
      .data7     (cfg_q.data7),
      .par_en    (cfg_q.par_en),
      .par_odd   (cfg_q.par_odd),
      .stop2     (cfg_q.stop2),
      .tdr_wr    (tdr_wr),
      .tdr_data  (tdr_data),
      .tdr_empty (tdr_empty),
      .txd       (txd),
      .busy      (tx_busy),
      .clk_lo    (tx_lo)
   );

   sercom_rx #(.DATA_W(DATA_W), .OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick     (tick),
      .re       (rx_en),
      .data7    (cfg_q.data7),
      .par_en   (cfg_q.par_en),
      .par_odd  (cfg_q.par_odd),
      .stop2    (cfg_q.stop2),
      .rxd      (rxd),
      .flag_clr (flag_clr),
      .rdr      (rdr),
      .rdr_full (rdr_full),
      .par_err  (par_err),
      .frm_err  (frm_err),
      .ovr_err  (ovr_err),
      .busy     (rx_busy),
      .clk_lo   (rx_lo)
   );

   assign clk_lo   = tx_busy ? tx_lo : rx_lo;
   assign sclk_out = ~(cfg_q.clk_out & ~cfg_q.ext_clk & clk_lo);

   a_r9_cfg_lock: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_en || rx_en) |=> $stable(cfg_q));

   a_r11_idle_clk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tx_busy && !rx_busy) |-> sclk_out);

   a_r11_ext_high: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_q.ext_clk |-> sclk_out);

endmodule

// File: tb/sercom_async_test.sv
module sercom_async_test;

   localparam int BITC = 64;  // clocks per bit with a tick every 4 clocks

   logic       clk = 0;
   logic       rst_n = 0;
   logic       int_tick = 0;
   logic       ext_sclk_in = 0;
   logic       cfg_ext_clk = 0, cfg_clk_out = 0, cfg_data7 = 0;
   logic       cfg_par_en = 0, cfg_par_odd = 0, cfg_stop2 = 0;
   logic       tx_en = 0, rx_en = 0, tdr_wr = 0, flag_clr = 0;
   logic [7:0] tdr_data = 0;
   logic       tdr_empty, txd, rdr_full, par_err, frm_err, ovr_err, sclk_out;
   logic [7:0] rdr;
   logic       loop = 1, drv_rxd = 1;
   logic       rxd_line;

   int checks = 0, fails = 0;
   int tdiv = 0;
   logic ext_run = 0;
   int ediv = 0;
   logic mon_en = 0, ext_watch = 0;
   int mon_cnt = 0, rises = 0, bad_rises = 0, ext_lows = 0;
   logic prev_txd = 1, prev_s = 1;

   assign rxd_line = loop ? txd : drv_rxd;

   always #10 clk = ~clk;

   always @(posedge clk) begin
      tdiv <= (tdiv + 1) % 4;
      int_tick <= (tdiv == 3);
   end

   always @(negedge clk) begin
      if (ext_run) begin
         ediv = (ediv + 1) % 4;
         if (ediv == 0) ext_sclk_in = ~ext_sclk_in;
      end
   end

   always @(negedge clk) begin
      if (mon_en) begin
         if (prev_txd && !txd) mon_cnt = 0;
         else mon_cnt = mon_cnt + 1;
         if (!prev_s && sclk_out) begin
            rises = rises + 1;
            if ((mon_cnt % BITC) != BITC / 2) bad_rises = bad_rises + 1;
         end
      end
      if (ext_watch && !sclk_out) ext_lows = ext_lows + 1;
      prev_txd = txd;
      prev_s   = sclk_out;
   end

   sercom_async uut (
      .clk(clk), .rst_n(rst_n), .int_tick(int_tick), .ext_sclk_in(ext_sclk_in),
      .cfg_ext_clk(cfg_ext_clk), .cfg_clk_out(cfg_clk_out), .cfg_data7(cfg_data7),
      .cfg_par_en(cfg_par_en), .cfg_par_odd(cfg_par_odd), .cfg_stop2(cfg_stop2),
      .tx_en(tx_en), .rx_en(rx_en), .tdr_wr(tdr_wr), .tdr_data(tdr_data),
      .tdr_empty(tdr_empty), .txd(txd), .rxd(rxd_line), .flag_clr(flag_clr),
      .rdr(rdr), .rdr_full(rdr_full), .par_err(par_err), .frm_err(frm_err),
      .ovr_err(ovr_err), .sclk_out(sclk_out)
   );

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic frame_bit(input logic [7:0] d, input bit d7, input bit pe,
                                      input bit po, input int i);
      int nd = d7 ? 7 : 8;
      int ones = 0;
      for (int k = 0; k < nd; k++) ones += d[k];
      if (i == 0) return 1'b0;
      if (i <= nd) return d[i-1];
      if (pe && i == nd + 1) return logic'((ones % 2) != (po ? 1 : 0));
      return 1'b1;
   endfunction

   function automatic int frame_len(input bit d7, input bit pe, input bit s2);
      return 1 + (d7 ? 7 : 8) + (pe ? 1 : 0) + (s2 ? 2 : 1);
   endfunction

   task automatic set_cfg(input bit ext, input bit co, input bit d7, input bit pe,
                          input bit po, input bit s2);
      @(negedge clk);
      tx_en = 0; rx_en = 0;
      cfg_ext_clk = ext; cfg_clk_out = co; cfg_data7 = d7;
      cfg_par_en = pe; cfg_par_odd = po; cfg_stop2 = s2;
      repeat (2) @(negedge clk);
   endtask

   task automatic write_tdr(input logic [7:0] d);
      @(negedge clk);
      tdr_data = d; tdr_wr = 1;
      @(negedge clk);
      tdr_wr = 0;
   endtask

   task automatic pulse_clr();
      @(negedge clk); flag_clr = 1;
      @(negedge clk); flag_clr = 0;
   endtask

   // samples each bit of one transmitted frame at its centre
   task automatic watch_frame(input logic [7:0] d, input bit d7, input bit pe, input bit po,
                              input bit s2, output int errs);
      int guard = 0;
      errs = 0;
      while (txd !== 1'b0 && guard < 400) begin @(negedge clk); guard++; end
      if (guard >= 400) errs = 99;
      repeat (BITC / 2) @(negedge clk);
      for (int i = 0; i < frame_len(d7, pe, s2); i++) begin
         if (txd !== frame_bit(d, d7, pe, po, i)) errs++;
         if (i < frame_len(d7, pe, s2) - 1) repeat (BITC) @(negedge clk);
      end
   endtask

   task automatic drive_frame(input logic [7:0] d, input bit d7, input bit pe, input bit po,
                              input bit s2, input bit badp, input bit bads);
      int n = frame_len(d7, pe, s2);
      int nd = d7 ? 7 : 8;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         drv_rxd = frame_bit(d, d7, pe, po, i);
         if (badp && pe && i == nd + 1) drv_rxd = ~drv_rxd;
         if (bads && i == nd + (pe ? 1 : 0) + 1) drv_rxd = 1'b0;
         repeat (BITC - 1) @(negedge clk);
      end
      @(negedge clk);
      drv_rxd = 1;
      repeat (20) @(negedge clk);
   endtask

   initial begin
      #(20 * 190000);
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
      $finish;
   end

   initial begin
      int errs;
      logic [7:0] vals [5] = '{8'h00, 8'hFF, 8'hA5, 8'h5A, 8'h81};
      repeat (3) @(negedge clk);
      check(txd === 1 && tdr_empty === 1, "R1 reset line/empty", {txd, tdr_empty}, 3);
      check(rdr_full === 0 && ovr_err === 0 && rdr === 0, "R12 reset rx state", rdr_full, 0);
      check(sclk_out === 1, "R11 reset clock high", sclk_out, 1);
      rst_n = 1;
      repeat (3) @(negedge clk);

      // format sweep in loopback
      for (int c = 0; c < 16; c++) begin
         bit d7 = c[3], pe = c[2], po = c[1], s2 = c[0];
         set_cfg(0, 1, d7, pe, po, s2);
         @(negedge clk); tx_en = 1; rx_en = 1; loop = 1; mon_en = 1;
         for (int k = 0; k < 5; k++) begin
            logic [7:0] expv;
            int guard = 0;
            write_tdr(vals[k]);
            watch_frame(vals[k], d7, pe, po, s2, errs);
            check(errs == 0, "R1 R3 transmitted frame bits", errs, 0);
            while (!rdr_full && guard < 300) begin @(negedge clk); guard++; end
            expv = d7 ? (vals[k] & 8'h7F) : vals[k];
            if (d7) check(rdr === expv, "R12 seven-bit receive", rdr, expv);
            else    check(rdr === expv, "R2 midpoint receive", rdr, expv);
            check({par_err, frm_err, ovr_err} === 3'b000, "R3 R4 no error on clean frame",
                  {par_err, frm_err, ovr_err}, 0);
            pulse_clr();
         end
         repeat (BITC) @(negedge clk);
         mon_en = 0;
      end
      check(rises > 500 && bad_rises == 0, "R11 clock rise at bit centre", bad_rises, 0);
      check(sclk_out === 1, "R11 idle clock high", sclk_out, 1);

      // holding register flag and transmit disable
      set_cfg(0, 1, 0, 0, 0, 0);
      @(negedge clk); tx_en = 1; rx_en = 0;
      write_tdr(8'h3C);
      check(tdr_empty === 0, "R6 write clears empty", tdr_empty, 0);
      repeat (8) @(negedge clk);
      check(tdr_empty === 1 && txd === 0, "R6 load sets empty", {tdr_empty, txd}, 2);
      write_tdr(8'hC3);
      repeat (8) @(negedge clk);
      check(tdr_empty === 0, "R6 held while busy", tdr_empty, 0);
      tx_en = 0;
      @(negedge clk);
      check(tdr_empty === 1 && txd === 1, "R7 disable forces empty", {tdr_empty, txd}, 3);
      errs = 0;
      repeat (200) begin @(negedge clk); if (txd !== 1) errs++; end
      check(errs == 0, "R7 frame abandoned", errs, 0);

      // configuration lock
      set_cfg(0, 0, 0, 0, 0, 0);
      @(negedge clk); tx_en = 1; rx_en = 1; loop = 1;
      cfg_data7 = 1; cfg_par_en = 1; cfg_stop2 = 1;
      write_tdr(8'hA5);
      watch_frame(8'hA5, 0, 0, 0, 0, errs);
      check(errs == 0, "R9 format change ignored on line", errs, 0);
      repeat (40) @(negedge clk);
      check(rdr === 8'hA5 && par_err === 0, "R9 format change ignored in rx", rdr, 8'hA5);
      pulse_clr();

      // receive error cases, line driven by bench
      set_cfg(0, 0, 0, 1, 0, 0);
      @(negedge clk); loop = 0; drv_rxd = 1; rx_en = 1;
      drive_frame(8'h3C, 0, 1, 0, 0, 0, 0);
      check(rdr === 8'h3C && rdr_full && !par_err, "R3 even parity good", rdr, 8'h3C);
      pulse_clr();
      drive_frame(8'h3D, 0, 1, 0, 0, 1, 0);
      check(par_err === 1 && rdr === 8'h3D, "R3 parity mismatch flagged", par_err, 1);
      pulse_clr();
      drive_frame(8'h42, 0, 1, 0, 0, 0, 1);
      check(frm_err === 1 && par_err === 0, "R4 low stop flagged", frm_err, 1);
      pulse_clr();
      repeat (BITC) @(negedge clk);
      drive_frame(8'h11, 0, 1, 0, 0, 0, 0);
      drive_frame(8'h22, 0, 1, 0, 0, 0, 0);
      check(ovr_err === 1 && rdr_full === 1, "R5 overrun flagged", ovr_err, 1);
      check(rdr === 8'h11, "R5 data kept on overrun", rdr, 8'h11);

      // receive disable keeps state
      @(negedge clk); rx_en = 0;
      drive_frame(8'h77, 0, 1, 0, 0, 1, 1);
      check(rdr === 8'h11 && rdr_full && ovr_err && !par_err && !frm_err,
            "R8 state kept while disabled", rdr, 8'h11);
      @(negedge clk); rx_en = 1;
      pulse_clr();
      check({rdr_full, par_err, frm_err, ovr_err} === 4'b0000, "R12 clear flags",
            {rdr_full, par_err, frm_err, ovr_err}, 0);

      // short glitch rejected, then a real frame still received
      @(negedge clk); drv_rxd = 0;
      repeat (16) @(negedge clk);
      drv_rxd = 1;
      repeat (1500) @(negedge clk);
      check(rdr_full === 0 && frm_err === 0, "R2 glitch rejected", rdr_full, 0);
      drive_frame(8'h96, 0, 1, 0, 0, 0, 0);
      check(rdr === 8'h96 && !par_err, "R2 frame after glitch", rdr, 8'h96);
      pulse_clr();

      // external tick source
      set_cfg(1, 1, 0, 0, 0, 0);
      @(negedge clk); loop = 1; ext_watch = 1; ext_lows = 0;
      tx_en = 1; rx_en = 1;
      write_tdr(8'h96);
      repeat (200) @(negedge clk);
      check(tdr_empty === 0 && txd === 1, "R10 internal tick ignored", {tdr_empty, txd}, 1);
      ext_run = 1;
      begin
         int guard = 0;
         while (!rdr_full && guard < 3000) begin @(negedge clk); guard++; end
         check(guard > 1100 && guard < 1400, "R10 sixteen edges per bit", guard, 1250);
      end
      check(rdr === 8'h96, "R10 external clock frame", rdr, 8'h96);
      check(ext_lows == 0, "R11 no clock out on external", ext_lows, 0);
      ext_watch = 0;

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule